// File: doc/BRIEF.md
# Reset Strap Capture and Configuration

This block qualifies the board-level reset pin of a 10/100 Ethernet PHY and turns the levels found on its multi-function pins into the device's starting configuration. A low level on the reset pin is accepted only after it has lasted a programmable number of clock cycles. Shorter low pulses leave the block untouched. While reset is in force, every configuration output sits at its default value. The shared pins are also kept in their input role during this time. On the cycle that reset is let go, the block takes one snapshot of the synchronized strap levels. It decodes that snapshot into a PHY address, an isolate flag, advertised abilities, the MAC interface mode, the crossover enable and an LED mode. One cycle later it hands the shared pins back to their normal output use.

After release, a small valid/ready write port lets the management logic replace the address, the advertised abilities or the LED mode. No write path reaches the isolate flag. That flag can only be set by strapping address zero at reset. An asynchronous power-on input puts the block into the reset state in the same way the qualified pin does.

Top module: `phy_strap_cfg`

## Requirements
- R1: A low level on `rst_pin_n` lasting fewer than `MIN_LOW_CYC` synchronized clock cycles has no effect on any output. A low level lasting `MIN_LOW_CYC` cycles or longer puts the block into reset (`cfg_reset_active` = 1).
- R2: From the cycle after reset is entered until reset ends, the outputs are: `phy_addr` = 5'b00001, `isolate` = 0, `adv_abil` = 4'b1111, `rmii_mode` = 0, `mdix_en` = 1, `led_mode` = 2'd1, `pins_release` = 0 and `wr_ready` = 0.
- R3: Every strap input passes through two synchronizer flops. The straps are captured on the clock edge at which the synchronized reset pin is seen high while the block is in reset. `phy_addr` then equals `strap_addr`.
- R4: `isolate` is 1 after capture exactly when the captured `strap_addr` is 0.
- R5: `adv_abil` bit 0 means 10 half duplex, bit 1 means 10 full duplex, bit 2 means 100 half duplex and bit 3 means 100 full duplex. `strap_an` 2'b00 gives 4'b0011, 2'b01 gives 4'b1100, 2'b10 gives 4'b0101 and 2'b11 gives 4'b1111.
- R6: `rmii_mode` equals the captured `strap_rmii`, and `mdix_en` equals the captured `strap_mdix`. `led_mode` is 2'd1 when `strap_led` was 1 and 2'd2 when it was 0.
- R7: `pins_release` rises one cycle after the capture edge. Strap levels that change after the capture edge have no effect on any output.
- R8: A write is accepted on an edge where both `wr_valid` and `wr_ready` are 1, and `wr_ready` equals `pins_release`. The write takes effect on that same edge. Target 0 loads `phy_addr` from `wr_data`. Target 1 loads `adv_abil` from `wr_data[3:0]`. Target 2 loads `led_mode` from `wr_data[1:0]`, but a value of 0 is ignored. Target 3 changes nothing.
- R9: No write changes `isolate`. In particular, writing address 0 leaves it 0, and writing a nonzero address after a strapped 0 leaves it 1.
- R10: A low level on `por_n` immediately gives the same state as a qualified reset: `cfg_reset_active` = 1, default outputs and `pins_release` = 0. The straps are captured once both `por_n` and the synchronized reset pin are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Raw board reset pin, active low, asynchronous |
| strap_addr | input | 5 | Raw PHY address strap levels |
| strap_an | input | 2 | Raw advertisement strap levels |
| strap_rmii | input | 1 | Raw interface-mode strap (1 = reduced interface) |
| strap_mdix | input | 1 | Raw crossover-enable strap |
| strap_led | input | 1 | Raw LED configuration strap |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write port ready; equal to pins_release |
| wr_target | input | 2 | Write target: 0 address, 1 advertisement, 2 LED mode, 3 none |
| wr_data | input | 5 | Write data |
| phy_addr | output | 5 | Current PHY address |
| isolate | output | 1 | Isolate-mode flag, strap only |
| adv_abil | output | 4 | Advertised abilities |
| rmii_mode | output | 1 | MAC interface mode, 1 = reduced interface |
| mdix_en | output | 1 | Automatic crossover enable |
| led_mode | output | 2 | LED mode code |
| pins_release | output | 1 | Shared pins handed to their output function |
| cfg_reset_active | output | 1 | Block is in qualified reset |

## Verification
A wrong low-pulse counter or reset flag shows up at the ports right away. A glitch would then reset `pins_release` and wipe a value that had been written, or a long pulse would fail to bring back the defaults. Either effect is visible within a few cycles of the pulse. A capture taken from the wrong synchronizer stage, or on the wrong edge, yields a wrong address or wrong ability bits as soon as `pins_release` rises. Straps that keep flowing through after capture change the outputs on the first strap toggle. A write path that reaches the isolate flag changes `isolate` on the cycle after the write.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int ADDR_W = 5;
  localparam int ADV_W  = 4;

  typedef enum logic [1:0] {
    LED_NONE  = 2'd0,
    LED_MODE1 = 2'd1,
    LED_MODE2 = 2'd2,
    LED_MODE3 = 2'd3
  } led_mode_e;

  typedef enum logic [1:0] {
    WT_ADDR = 2'd0,
    WT_ADV  = 2'd1,
    WT_LED  = 2'd2,
    WT_NONE = 2'd3
  } wr_tgt_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        an;
    logic              rmii;
    logic              mdix;
    logic              led;
  } strap_t;

  localparam int STRAP_W = $bits(strap_t);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              isolate;
    logic [ADV_W-1:0]  adv;
    logic              rmii;
    logic              mdix;
    led_mode_e         led;
  } cfg_t;

  // levels the pins take with no external strap (internal pulls)
  localparam strap_t STRAP_DEFAULT = '{addr: 5'b00001, an: 2'b11, rmii: 1'b0,
                                       mdix: 1'b1, led: 1'b1};

  localparam cfg_t CFG_DEFAULT = '{addr: 5'b00001, isolate: 1'b0, adv: 4'b1111,
                                   rmii: 1'b0, mdix: 1'b1, led: LED_MODE1};

  // adv bit0 10HD, bit1 10FD, bit2 100HD, bit3 100FD
  function automatic logic [ADV_W-1:0] an_decode(input logic [1:0] an);
    case (an)
      2'b00:   an_decode = 4'b0011;
      2'b01:   an_decode = 4'b1100;
      2'b10:   an_decode = 4'b0101;
      default: an_decode = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/psc_rst_qual.sv
module psc_rst_qual #(
  parameter int MIN_LOW_CYC = 25
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_s,      // synchronized reset pin, active low
  output logic in_reset,
  output logic capture,
  output logic release_q
);
  localparam int CNT_W = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(MIN_LOW_CYC);

  logic [CNT_W-1:0] low_cnt;
  logic             enter;

  assign enter   = !pin_s && !in_reset && (low_cnt == LAST);
  assign capture = in_reset && pin_s;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               low_cnt <= '0;
    else if (pin_s)           low_cnt <= '0;
    else if (low_cnt != SAT)  low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       in_reset <= 1'b1;
    else if (enter)   in_reset <= 1'b1;
    else if (capture) in_reset <= 1'b0;
  end

  // pins go back to outputs one cycle after the snapshot
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     release_q <= 1'b0;
    else if (enter) release_q <= 1'b0;
    else            release_q <= !in_reset;
  end
endmodule

// File: rtl/psc_cfg_regs.sv
module psc_cfg_regs
  import psc_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  strap_t            strap,
  input  logic              capture,
  input  logic              in_reset,
  input  logic              wr_fire,
  input  logic [1:0]        wr_target,
  input  logic [ADDR_W-1:0] wr_data,
  output cfg_t              cfg
);
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg;
    if (capture) begin
      cfg_d.addr    = strap.addr;
      cfg_d.isolate = (strap.addr == '0);
      cfg_d.adv     = an_decode(strap.an);
      cfg_d.rmii    = strap.rmii;
      cfg_d.mdix    = strap.mdix;
      cfg_d.led     = strap.led ? LED_MODE1 : LED_MODE2;
    end else if (in_reset) begin
      cfg_d = CFG_DEFAULT;
    end else if (wr_fire) begin
      case (wr_tgt_e'(wr_target))
        WT_ADDR: cfg_d.addr = wr_data;
        WT_ADV:  cfg_d.adv  = wr_data[ADV_W-1:0];
        WT_LED:  if (wr_data[1:0] != 2'd0) cfg_d.led = led_mode_e'(wr_data[1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cfg <= CFG_DEFAULT;
    else        cfg <= cfg_d;
  end
endmodule

// File: rtl/phy_strap_cfg.sv
module phy_strap_cfg
  import psc_pkg::*;
#(
  parameter int MIN_LOW_CYC = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic [1:0]        strap_an,
  input  logic              strap_rmii,
  input  logic              strap_mdix,
  input  logic              strap_led,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [1:0]        wr_target,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              isolate,
  output logic [ADV_W-1:0]  adv_abil,
  output logic              rmii_mode,
  output logic              mdix_en,
  output logic [1:0]        led_mode,
  output logic              pins_release,
  output logic              cfg_reset_active
);
  strap_t strap_raw, strap_s;
  logic   pin_s, in_reset, capture, release_q;
  cfg_t   cfg;

  assign strap_raw = '{addr: strap_addr, an: strap_an, rmii: strap_rmii,
                       mdix: strap_mdix, led: strap_led};

  psc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .por_n(por_n), .d(rst_pin_n), .q(pin_s));

  psc_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL(STRAP_DEFAULT)) u_strap_sync (
    .clk(clk), .por_n(por_n), .d(strap_raw), .q(strap_s));

  psc_rst_qual #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_qual (
    .clk(clk), .por_n(por_n), .pin_s(pin_s),
    .in_reset(in_reset), .capture(capture), .release_q(release_q));

  psc_cfg_regs u_regs (
    .clk(clk), .por_n(por_n), .strap(strap_s), .capture(capture),
    .in_reset(in_reset), .wr_fire(wr_valid && release_q),
    .wr_target(wr_target), .wr_data(wr_data), .cfg(cfg));

  assign wr_ready         = release_q;
  assign pins_release     = release_q;
  assign cfg_reset_active = in_reset;
  assign phy_addr         = cfg.addr;
  assign isolate          = cfg.isolate;
  assign adv_abil         = cfg.adv;
  assign rmii_mode        = cfg.rmii;
  assign mdix_en          = cfg.mdix;
  assign led_mode         = cfg.led;
endmodule

// File: rtl/phy_strap_cfg_chk.sv
module phy_strap_cfg_chk (
  input logic       clk,
  input logic       por_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [1:0] wr_target,
  input logic [4:0] wr_data,
  input logic [4:0] phy_addr,
  input logic       isolate,
  input logic [3:0] adv_abil,
  input logic       rmii_mode,
  input logic       mdix_en,
  input logic [1:0] led_mode,
  input logic       pins_release,
  input logic       cfg_reset_active
);
  assert_no_release_in_reset_R2: assert property (@(posedge clk) disable iff (!por_n)
    cfg_reset_active |-> (!pins_release && !wr_ready));

  assert_defaults_in_reset_R2: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_reset_active && $past(cfg_reset_active)) |->
      (phy_addr == 5'b00001 && !isolate && adv_abil == 4'b1111 &&
       !rmii_mode && mdix_en && led_mode == 2'd1));

  assert_release_follows_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(cfg_reset_active) |=> pins_release);

  assert_release_needs_exit_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pins_release) |-> (!cfg_reset_active && !$past(pins_release)));

  assert_addr_write_R8: assert property (@(posedge clk) disable iff (!por_n)
    (wr_valid && wr_ready && wr_target == 2'd0) |=> (phy_addr == $past(wr_data)));

  assert_adv_write_R8: assert property (@(posedge clk) disable iff (!por_n)
    (wr_valid && wr_ready && wr_target == 2'd1) |=> (adv_abil == $past(wr_data[3:0])));

  assert_isolate_no_write_R9: assert property (@(posedge clk) disable iff (!por_n)
    (!cfg_reset_active && !$past(cfg_reset_active)) |-> $stable(isolate));
endmodule

bind phy_strap_cfg phy_strap_cfg_chk u_chk (
  .clk(clk), .por_n(por_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_target(wr_target), .wr_data(wr_data), .phy_addr(phy_addr),
  .isolate(isolate), .adv_abil(adv_abil), .rmii_mode(rmii_mode),
  .mdix_en(mdix_en), .led_mode(led_mode), .pins_release(pins_release),
  .cfg_reset_active(cfg_reset_active));

// File: tb/phy_strap_cfg_test.sv
module phy_strap_cfg_test;
  localparam int MIN = 6;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_pin_n = 1'b1;
  logic [4:0] strap_addr = 5'd1;
  logic [1:0] strap_an = 2'b11;
  logic       strap_rmii = 1'b0, strap_mdix = 1'b1, strap_led = 1'b1;
  logic       wr_valid = 1'b0;
  logic [1:0] wr_target = 2'd0;
  logic [4:0] wr_data = 5'd0;
  logic       wr_ready, isolate, rmii_mode, mdix_en, pins_release, cfg_reset_active;
  logic [4:0] phy_addr;
  logic [3:0] adv_abil;
  logic [1:0] led_mode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phy_strap_cfg #(.MIN_LOW_CYC(MIN)) uut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .strap_addr(strap_addr),
    .strap_an(strap_an), .strap_rmii(strap_rmii), .strap_mdix(strap_mdix),
    .strap_led(strap_led), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_target(wr_target), .wr_data(wr_data), .phy_addr(phy_addr),
    .isolate(isolate), .adv_abil(adv_abil), .rmii_mode(rmii_mode),
    .mdix_en(mdix_en), .led_mode(led_mode), .pins_release(pins_release),
    .cfg_reset_active(cfg_reset_active));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_adv(input logic [1:0] an);
    case (an)
      2'b00: return 4'b0011;
      2'b01: return 4'b1100;
      2'b10: return 4'b0101;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check_defaults(input string req);
    chk({req, " addr"}, phy_addr, 1);
    chk({req, " isolate"}, isolate, 0);
    chk({req, " adv"}, adv_abil, 15);
    chk({req, " rmii"}, rmii_mode, 0);
    chk({req, " mdix"}, mdix_en, 1);
    chk({req, " led"}, led_mode, 1);
    chk({req, " release"}, pins_release, 0);
    chk({req, " ready"}, wr_ready, 0);
  endtask

  // low pulse of n cycles, then release and let capture settle
  task automatic pulse(input int n, input bit check_in_reset);
    @(negedge clk);
    rst_pin_n = 1'b0;
    wait_n(n);
    if (check_in_reset) begin
      chk("R1 in reset", cfg_reset_active, 1);
      check_defaults("R2");
    end
    rst_pin_n = 1'b1;
    wait_n(6);
  endtask

  task automatic wr(input logic [1:0] t, input logic [4:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_target = t; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    logic [4:0] a_keep;
    wait_n(3);
    por_n = 1'b1;
    wait_n(6);
    chk("R10 release after por", pins_release, 1);
    chk("R10 default addr captured", phy_addr, 1);

    // sweep all addresses with every strap combination pattern
    for (int i = 0; i < 128; i++) begin
      logic [4:0] a;
      logic [1:0] an;
      logic rm, md, ld;
      a  = i[4:0];
      an = i[6:5];
      rm = i[0] ^ i[6];
      md = i[1] ^ i[5];
      ld = i[2] ^ i[6];
      strap_addr = a; strap_an = an; strap_rmii = rm; strap_mdix = md; strap_led = ld;
      pulse(MIN + 4, (i % 16) == 0);
      chk("R3 addr", phy_addr, a);
      chk("R4 isolate", isolate, (a == 0) ? 1 : 0);
      chk("R5 adv", adv_abil, exp_adv(an));
      chk("R6 rmii", rmii_mode, rm);
      chk("R6 mdix", mdix_en, md);
      chk("R6 led", led_mode, ld ? 1 : 2);
      chk("R7 release", pins_release, 1);
      chk("R8 ready", wr_ready, 1);
      // straps moving after capture must not matter
      strap_addr = ~a; strap_an = ~an; strap_rmii = ~rm; strap_mdix = ~md; strap_led = ~ld;
      wait_n(4);
      chk("R7 addr held", phy_addr, a);
      chk("R7 adv held", adv_abil, exp_adv(an));
      chk("R7 modes held", {rmii_mode, mdix_en}, {rm, md});
      chk("R7 led held", led_mode, ld ? 1 : 2);
    end

    // glitch filter
    strap_addr = 5'd5; strap_an = 2'b11;
    pulse(MIN + 4, 1'b0);
    wr(2'd0, 5'd9);
    chk("R8 addr write", phy_addr, 9);
    strap_addr = 5'd21;
    pulse(MIN - 1, 1'b0);
    chk("R1 glitch keeps addr", phy_addr, 9);
    chk("R1 glitch keeps release", pins_release, 1);
    pulse(MIN, 1'b0);
    chk("R1 minimum pulse recaptures", phy_addr, 21);

    // isolate from strap only
    strap_addr = 5'd0;
    pulse(MIN + 4, 1'b0);
    chk("R4 strapped zero", isolate, 1);
    wr(2'd0, 5'd7);
    chk("R8 addr write", phy_addr, 7);
    chk("R9 isolate kept set", isolate, 1);
    strap_addr = 5'd3;
    pulse(MIN + 4, 1'b0);
    wr(2'd0, 5'd0);
    chk("R8 addr write zero", phy_addr, 0);
    chk("R9 isolate stays clear", isolate, 0);

    // other targets
    wr(2'd1, 5'b01010);
    chk("R8 adv write", adv_abil, 4'b1010);
    wr(2'd2, 5'd3);
    chk("R8 led write", led_mode, 3);
    wr(2'd2, 5'd0);
    chk("R8 led zero ignored", led_mode, 3);
    a_keep = phy_addr;
    wr(2'd3, 5'd17);
    chk("R8 target3 addr", phy_addr, a_keep);
    chk("R8 target3 adv", adv_abil, 4'b1010);
    chk("R8 target3 led", led_mode, 3);

    // write while in reset is refused
    @(negedge clk);
    rst_pin_n = 1'b0;
    wait_n(MIN + 4);
    wr(2'd0, 5'd12);
    chk("R2 write refused in reset", phy_addr, 1);
    rst_pin_n = 1'b1;
    wait_n(6);
    chk("R3 addr after refused write", phy_addr, 3);

    // power-on reset
    @(negedge clk);
    por_n = 1'b0;
    #1;
    chk("R10 reset active", cfg_reset_active, 1);
    check_defaults("R10");
    strap_addr = 5'd30; strap_an = 2'b10;
    @(negedge clk);
    por_n = 1'b1;
    wait_n(6);
    chk("R10 capture addr", phy_addr, 30);
    chk("R10 capture adv", adv_abil, 4'b0101);
    chk("R10 released", pins_release, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule